// File: doc/BRIEF.md
# Ternary CAM longest-prefix matcher

This block resolves a 32-bit destination address to a next-hop identifier in one lookup. It holds a small table of route entries. Each entry has a stored value, a care mask, a valid bit and a next-hop id. A bit whose care mask is 0 is a don't-care, so every stored bit acts as 0, 1 or wildcard. A lookup key is compared against every entry at the same time. A priority picker then selects the lowest-numbered entry that matches, and that entry's next-hop id is returned.

Software keeps the table sorted from the longest prefix to the shortest, with a zero-length default route in the last slot. Under that ordering the lowest-index match is always the longest match. Entries are loaded through a write port that takes a prefix value and a prefix length. The block builds the care mask itself: the top L bits are set and the rest are cleared. The result is registered and comes out on the cycle after the request, together with a hit flag and the index of the winning entry.

Top module: `lpm_tcam`

## Requirements
- R1: After reset every entry is invalid and res_valid, res_hit, res_idx and res_nh are all 0. Any lookup made before the first write misses.
- R2: A write (wr_en=1) stores wr_key, wr_len, wr_nh and wr_valid into slot wr_idx at the clock edge. A lookup presented in the same cycle as the write sees the old contents, and a lookup in the following cycle sees the new contents.
- R3: An entry of length L (0 to 32) matches a key when the key's L most significant bits equal the stored value's L most significant bits. The remaining low bits are ignored, and a write with wr_len above 32 is treated as length 32.
- R4: When several valid entries match, the result is the one with the lowest index, regardless of the entries' lengths.
- R5: res_valid is 1 exactly in the cycle after a cycle with lk_req=1. In a cycle after lk_req=0, res_hit, res_idx and res_nh keep their previous values.
- R6: A lookup that matches no entry gives res_hit=0, res_idx=0 and res_nh=0.
- R7: An entry written with wr_valid=0 never matches, so rewriting a slot with wr_valid=0 removes its route.
- R8: A valid entry of length 0 matches every key. Placed in the last slot, it supplies the result for every key that no longer entry covers.
- R9: With entries of lengths 4,4,4,3,2,2,0 holding the top-bit prefixes 0111, 0110, 0010, 110, 01, 10 and empty in slots 0 to 6, a key with top bits 0010 returns slot 2. Key 0101 returns slot 4, key 1101 returns slot 3, key 1000 returns slot 5 and key 1110 returns slot 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one table slot |
| wr_idx | input | IDX_W (4) | Slot being written |
| wr_valid | input | 1 | Valid bit stored with the entry |
| wr_key | input | KEY_W (32) | Prefix value; bits below the prefix are discarded |
| wr_len | input | LEN_W (6) | Prefix length in bits |
| wr_nh | input | NH_W (8) | Next-hop id stored with the entry |
| lk_req | input | 1 | Lookup request |
| lk_key | input | KEY_W (32) | Lookup key (destination address) |
| res_valid | output | 1 | Result present, one cycle after lk_req |
| res_hit | output | 1 | At least one entry matched |
| res_idx | output | IDX_W (4) | Index of the winning entry, 0 on a miss |
| res_nh | output | NH_W (8) | Next-hop id of the winner, 0 on a miss |

## Verification
A table write and a lookup can land in the same cycle. The lookup must then be answered from the table as it was before the edge. The bench provokes this on purpose: it writes a slot while looking up a key that only the new entry would match, expects a miss, and repeats the lookup on the next cycle to expect the hit. The bench also overwrites a slot that currently wins while looking it up. During the random phase it issues writes and lookups together in most cycles, and its behavioural model applies each write only after it has computed the expected lookup result.

// File: rtl/lpm_tcam_pkg.sv
package lpm_tcam_pkg;

   typedef enum logic [0:0] {
      PRIO_LINEAR  = 1'b0,
      PRIO_GROUPED = 1'b1
   } prio_style_e;

endpackage

// File: rtl/lpm_entry_bank.sv
module lpm_entry_bank
#(
   parameter int KEY_W = 32,
   parameter int DEPTH = 16,
   parameter int NH_W  = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LEN_W = $clog2(KEY_W + 1)
)
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic                        wr_valid,
   input  logic [KEY_W-1:0]            wr_key,
   input  logic [LEN_W-1:0]            wr_len,
   input  logic [NH_W-1:0]             wr_nh,
   output logic [DEPTH-1:0]            ent_valid,
   output logic [DEPTH-1:0][KEY_W-1:0] ent_value,
   output logic [DEPTH-1:0][KEY_W-1:0] ent_care,
   output logic [DEPTH-1:0][NH_W-1:0]  ent_nh
);

   logic [LEN_W-1:0] len_clamped;
   logic [KEY_W-1:0] care_new;

   always_comb begin
      if (int'(wr_len) > KEY_W) len_clamped = LEN_W'(KEY_W);
      else                      len_clamped = wr_len;
   end

   // top len_clamped bits set, rest cleared
   assign care_new = ~({KEY_W{1'b1}} >> len_clamped);

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (int'(wr_idx) == e);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_value[e] <= '0;
            ent_care[e]  <= '0;
            ent_nh[e]    <= '0;
         end else if (sel) begin
            ent_valid[e] <= wr_valid;
            ent_value[e] <= wr_key & care_new;
            ent_care[e]  <= care_new;
            ent_nh[e]    <= wr_nh;
         end
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) < DEPTH) |=> ent_valid[$past(wr_idx)] == $past(wr_valid)); // R2

endmodule

// File: rtl/lpm_match_array.sv
module lpm_match_array
#(
   parameter int KEY_W = 32,
   parameter int DEPTH = 16
)
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [KEY_W-1:0]            key,
   input  logic [DEPTH-1:0]            ent_valid,
   input  logic [DEPTH-1:0][KEY_W-1:0] ent_value,
   input  logic [DEPTH-1:0][KEY_W-1:0] ent_care,
   output logic [DEPTH-1:0]            hit_vec
);

   for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      logic [KEY_W-1:0] diff;
      assign diff       = (key ^ ent_value[e]) & ent_care[e];
      assign hit_vec[e] = ent_valid[e] && (diff == '0);

      AST_WILDCARD_HITS: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_valid[e] && ent_care[e] == '0) |-> hit_vec[e]); // R8
   end

endmodule

// File: rtl/lpm_prio_pick.sv
module lpm_prio_pick
   import lpm_tcam_pkg::*;
#(
   parameter int          DEPTH   = 16,
   parameter prio_style_e STYLE   = PRIO_GROUPED,
   parameter int          GROUP_W = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)
(
   input  logic [DEPTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (STYLE == PRIO_LINEAR) begin : g_linear
      always_comb begin
         any = 1'b0;
         idx = '0;
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
               any = 1'b1;
               idx = IDX_W'(i);
            end
         end
      end
   end else begin : g_grouped
      localparam int NGROUP = (DEPTH + GROUP_W - 1) / GROUP_W;
      localparam int PAD_W  = NGROUP * GROUP_W;
      localparam int LW     = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;

      logic [PAD_W-1:0]           req_pad;
      logic [NGROUP-1:0]          grp_any;
      logic [NGROUP-1:0][LW-1:0]  grp_idx;

      always_comb begin
         req_pad = '0;
         req_pad[DEPTH-1:0] = req;
      end

      for (genvar g = 0; g < NGROUP; g++) begin : g_grp
         logic [GROUP_W-1:0] slice;
         assign slice = req_pad[g*GROUP_W +: GROUP_W];
         always_comb begin
            grp_any[g] = 1'b0;
            grp_idx[g] = '0;
            for (int j = GROUP_W - 1; j >= 0; j--) begin
               if (slice[j]) begin
                  grp_any[g] = 1'b1;
                  grp_idx[g] = LW'(j);
               end
            end
         end
      end

      always_comb begin
         int base;
         any  = 1'b0;
         idx  = '0;
         base = 0;
         for (int g = NGROUP - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
               any  = 1'b1;
               base = g * GROUP_W + int'(grp_idx[g]);
               idx  = IDX_W'(base);
            end
         end
      end
   end

endmodule

// File: rtl/lpm_tcam.sv
module lpm_tcam
   import lpm_tcam_pkg::*;
#(
   parameter int          KEY_W   = 32,
   parameter int          DEPTH   = 16,
   parameter int          NH_W    = 8,
   parameter prio_style_e STYLE   = PRIO_GROUPED,
   parameter int          GROUP_W = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LEN_W = $clog2(KEY_W + 1)
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [LEN_W-1:0] wr_len,
   input  logic [NH_W-1:0]  wr_nh,
   input  logic             lk_req,
   input  logic [KEY_W-1:0] lk_key,
   output logic             res_valid,
   output logic             res_hit,
   output logic [IDX_W-1:0] res_idx,
   output logic [NH_W-1:0]  res_nh
);

   if (KEY_W < 1)   begin : g_bad_key   $error("KEY_W must be at least 1");   end
   if (DEPTH < 2)   begin : g_bad_depth $error("DEPTH must be at least 2");   end
   if (NH_W < 1)    begin : g_bad_nh    $error("NH_W must be at least 1");    end
   if (GROUP_W < 1) begin : g_bad_grp   $error("GROUP_W must be at least 1"); end

   logic [DEPTH-1:0]            ent_valid;
   logic [DEPTH-1:0][KEY_W-1:0] ent_value;
   logic [DEPTH-1:0][KEY_W-1:0] ent_care;
   logic [DEPTH-1:0][NH_W-1:0]  ent_nh;
   logic [DEPTH-1:0]            hit_vec;
   logic                        pick_any;
   logic [IDX_W-1:0]            pick_idx;

   lpm_entry_bank #(.KEY_W(KEY_W), .DEPTH(DEPTH), .NH_W(NH_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_valid  (wr_valid),
      .wr_key    (wr_key),
      .wr_len    (wr_len),
      .wr_nh     (wr_nh),
      .ent_valid (ent_valid),
      .ent_value (ent_value),
      .ent_care  (ent_care),
      .ent_nh    (ent_nh)
   );

   lpm_match_array #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .key       (lk_key),
      .ent_valid (ent_valid),
      .ent_value (ent_value),
      .ent_care  (ent_care),
      .hit_vec   (hit_vec)
   );

   lpm_prio_pick #(.DEPTH(DEPTH), .STYLE(STYLE), .GROUP_W(GROUP_W)) u_pick (
      .req (hit_vec),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_idx   <= '0;
         res_nh    <= '0;
      end else begin
         res_valid <= lk_req;
         if (lk_req) begin
            res_hit <= pick_any;
            res_idx <= pick_any ? pick_idx : '0;
            res_nh  <= pick_any ? ent_nh[pick_idx] : '0;
         end
      end
   end

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> res_valid); // R5

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !res_valid); // R5

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> ($stable(res_hit) && $stable(res_idx) && $stable(res_nh))); // R5

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_idx == '0 && res_nh == '0)); // R6

   AST_WINNER_WAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |-> ((($past(ent_valid) >> res_idx) & DEPTH'(1)) != '0)); // R7

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |->
         (($past(hit_vec) & ((DEPTH'(1) << res_idx) - DEPTH'(1))) == '0)); // R4

endmodule

// File: tb/lpm_tcam_tb.sv
module lpm_tcam_tb;

   localparam int CLK_PERIOD = 10;
   localparam int KEY_W = 32;
   localparam int DEPTH = 16;
   localparam int NH_W  = 8;
   localparam int IDX_W = 4;
   localparam int LEN_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic             wr_valid = 1'b0;
   logic [KEY_W-1:0] wr_key = '0;
   logic [LEN_W-1:0] wr_len = '0;
   logic [NH_W-1:0]  wr_nh = '0;
   logic             lk_req = 1'b0;
   logic [KEY_W-1:0] lk_key = '0;
   logic             res_valid;
   logic             res_hit;
   logic [IDX_W-1:0] res_idx;
   logic [NH_W-1:0]  res_nh;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_tcam u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_key(wr_key),
      .wr_len(wr_len), .wr_nh(wr_nh),
      .lk_req(lk_req), .lk_key(lk_key),
      .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_nh(res_nh)
   );

   // behavioural reference table
   logic [KEY_W-1:0] m_val [DEPTH];
   int               m_len [DEPTH];
   logic [NH_W-1:0]  m_nh  [DEPTH];
   bit               m_v   [DEPTH];

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string tag = "R1";

   logic            e_valid = 1'b0;
   logic            e_hit = 1'b0;
   int              e_idx = 0;
   logic [NH_W-1:0] e_nh = '0;

   function automatic bit model_match(logic [KEY_W-1:0] k, int i);
      int n;
      n = (m_len[i] > KEY_W) ? KEY_W : m_len[i];
      for (int b = 0; b < n; b++)
         if (k[KEY_W-1-b] != m_val[i][KEY_W-1-b]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check_now();
      checks++;
      if (res_valid !== e_valid || res_hit !== e_hit ||
          int'(res_idx) != e_idx || res_nh !== e_nh) begin
         failures++;
         $display("FAIL %s: valid/hit/idx/nh actual %0b/%0b/%0d/%0h expected %0b/%0b/%0d/%0h",
                  tag, res_valid, res_hit, res_idx, res_nh, e_valid, e_hit, e_idx, e_nh);
      end
   endtask

   task automatic cycle(input bit w, input int wi, input bit wv, input logic [KEY_W-1:0] wk,
                        input int wl, input int wn, input bit l, input logic [KEY_W-1:0] lk);
      wr_en = w; wr_idx = IDX_W'(wi); wr_valid = wv; wr_key = wk;
      wr_len = LEN_W'(wl); wr_nh = NH_W'(wn); lk_req = l; lk_key = lk;
      @(posedge clk);
      e_valid = l;
      if (l) begin
         e_hit = 1'b0; e_idx = 0; e_nh = '0;
         for (int i = 0; i < DEPTH; i++) begin
            if (!e_hit && m_v[i] && model_match(lk, i)) begin
               e_hit = 1'b1; e_idx = i; e_nh = m_nh[i];
            end
         end
      end
      if (w) begin
         m_v[wi] = wv; m_val[wi] = wk; m_len[wi] = wl; m_nh[wi] = NH_W'(wn);
      end
      #1;
      check_now();
   endtask

   task automatic wr(input int wi, input bit wv, input logic [KEY_W-1:0] wk, input int wl, input int wn);
      cycle(1'b1, wi, wv, wk, wl, wn, 1'b0, '0);
   endtask

   task automatic look(input logic [KEY_W-1:0] k);
      cycle(1'b0, 0, 1'b0, '0, 0, 0, 1'b1, k);
   endtask

   task automatic idle();
      cycle(1'b0, 0, 1'b0, '0, 0, 0, 1'b0, '0);
   endtask

   task automatic clear_all();
      for (int i = 0; i < DEPTH; i++) wr(i, 1'b0, '0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_v[i] = 1'b0; m_val[i] = '0; m_len[i] = 0; m_nh[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: outputs reset, table empty
      tag = "R1";
      check_now();
      look(32'h0A020002);
      look(32'h00000000);
      look(32'hFFFFFFFF);
      idle();

      // R2: write and lookup in the same cycle see old table
      tag = "R2";
      cycle(1'b1, 3, 1'b1, 32'h0A010000, 16, 8'h33, 1'b1, 32'h0A01ABCD);
      look(32'h0A01ABCD);
      cycle(1'b1, 3, 1'b1, 32'h0A020000, 16, 8'h44, 1'b1, 32'h0A01ABCD);
      look(32'h0A01ABCD);
      look(32'h0A02FFFF);

      // R3: length boundaries
      tag = "R3";
      clear_all();
      wr(0, 1'b1, 32'hC0A80101, 32, 8'h01);
      look(32'hC0A80101);
      look(32'hC0A80100);
      wr(1, 1'b1, 32'h0A0102FF, 24, 8'h02);
      look(32'h0A010277);
      look(32'h0A010377);
      wr(2, 1'b1, 32'h80000000, 1, 8'h03);
      look(32'h9FFFFFFF);
      look(32'h7FFFFFFF);
      wr(3, 1'b1, 32'h12345678, 40, 8'h04);
      look(32'h12345678);
      look(32'h12345679);

      // R4: lowest index wins even when shorter
      tag = "R4";
      clear_all();
      wr(1, 1'b1, 32'h0A000000, 8, 8'h11);
      wr(5, 1'b1, 32'h0A010000, 16, 8'h55);
      wr(9, 1'b1, 32'h0A010100, 24, 8'h99);
      look(32'h0A010105);
      look(32'h0B010105);
      wr(1, 1'b0, 32'h0A000000, 8, 8'h11);
      // R7: removed slot no longer matches
      tag = "R7";
      look(32'h0A010105);
      look(32'h0A7F0000);

      // R6: miss
      tag = "R6";
      look(32'hDEADBEEF);
      idle();
      idle();

      // R8: default route
      tag = "R8";
      wr(15, 1'b1, 32'hFFFFFFFF, 0, 8'hEE);
      look(32'hDEADBEEF);
      look(32'h0A010105);
      look(32'h00000000);

      // R9: sorted ternary example in top four bits
      tag = "R9";
      clear_all();
      wr(0, 1'b1, 32'h70000000, 4, 8'h67);
      wr(1, 1'b1, 32'h60000000, 4, 8'h66);
      wr(2, 1'b1, 32'h20000000, 4, 8'h65);
      wr(3, 1'b1, 32'hC0000000, 3, 8'h64);
      wr(4, 1'b1, 32'h40000000, 2, 8'h63);
      wr(5, 1'b1, 32'h80000000, 2, 8'h62);
      wr(6, 1'b1, 32'h00000000, 0, 8'h61);
      look(32'h2ABCDEF0);
      look(32'h50000000);
      look(32'hD0000000);
      look(32'h80000000);
      look(32'hE0000000);
      look(32'h70000001);

      // R5: idle cycles hold result and drop valid; random mix
      tag = "R5";
      idle();
      look(32'h60000000);
      idle();
      idle();
      tag = "R2";
      for (int t = 0; t < 600; t++) begin
         bit w, l;
         int wi, wl;
         logic [KEY_W-1:0] wk, lk;
         w  = ($urandom_range(0, 3) != 0);
         l  = ($urandom_range(0, 4) != 0);
         wi = $urandom_range(0, DEPTH - 1);
         wl = $urandom_range(0, 33);
         wk = {4'($urandom_range(0, 15)), 28'($urandom)};
         lk = {4'($urandom_range(0, 15)), 28'($urandom)};
         if ($urandom_range(0, 1) == 1) lk = m_val[$urandom_range(0, DEPTH - 1)] ^ 32'($urandom_range(0, 255));
         cycle(w, wi, ($urandom_range(0, 5) != 0), wk, wl, $urandom_range(0, 255), l, lk);
      end
      idle();
      finish_run();
   end

endmodule